// File: doc/BRIEF.md
# Tagged-Token Operand Matching Unit

This block is the firing core of one data-driven processing element. Tokens arrive on a valid/ready stream. Each token names a target instruction slot, one of two operand sides (left or right) and a 16-bit value. The instruction in that slot is read from a small program memory that is loaded through a plain write port. A single-operand instruction executes as soon as its token arrives. A two-operand instruction parks the first operand it receives in a per-slot operand store and sets that slot's presence flag. It executes when the partner operand arrives, and the flag is then cleared so the slot can match again for a later wave of tokens.

The result of an instruction is computed by a small integer ALU. It is then sent as one output token to each destination that the instruction word lists, on a second valid/ready stream. That stream may be wired back to the input. Slots work independently of each other: while one slot waits for a partner, tokens for other slots keep being accepted and executed.

Back-pressure rules: an output token stays on the output, unchanged, until `out_ready` is high at a clock edge. While any result token is still waiting to be taken, or while a token sits in the match stage, `in_ready` is low and no new token is accepted.

Top module: `ttm_fire_core`

## Requirements
- R1: After reset `in_ready` is high, `out_valid` is low and every presence flag is clear. A token is taken at a rising edge where `in_valid` and `in_ready` are both high.
- R2: An instruction whose arity bit is 0 executes on the first token addressed to it, whatever that token's port. The token value is the left operand and the right operand is 0.
- R3: The first token that reaches a two-operand instruction (arity bit 1) with its flag clear is stored together with its port. The flag is set and no output token results.
- R4: The second token executes the instruction. The parked operand takes the side named by its own port (0 = left, 1 = right), and the arriving operand takes the other side, so arrival order does not change the result. Firing clears the flag, so the slot matches again afterwards.
- R5: Opcodes: 0 passes left, 1 gives left+right, 2 gives left-right, 3 gives the low 16 bits of left*right, 4 gives AND, 5 gives OR, 6 gives XOR, 7 gives 1 if left > right (unsigned) and 0 otherwise, and 8 gives the two's-complement negation of left. Opcodes 9 to 15 pass left.
- R6: The instruction word is 25 bits. Bits [24:21] hold the opcode and bit [20] the arity. The first destination is at bit [19] (valid), bits [18:11] (slot address) and bit [10] (port). The second destination is at bit [9] (valid), bits [8:1] (address) and bit [0] (port). A word is written to slot `prog_addr` at a rising edge where `prog_we` is high.
- R7: Each valid destination produces one output token that carries the result and that destination's address and port. The first destination goes out before the second. When `out_ready` stays high, the two tokens go out on consecutive cycles. An instruction with no valid destination executes but emits nothing.
- R8: While `out_valid` is high and `out_ready` is low, the output token holds steady. `in_ready` is low whenever `out_valid` is high.
- R9: A token parked in one slot is not disturbed while tokens for other slots are accepted and executed.
- R10: When a token causes an instruction to fire, `out_valid` rises in the cycle after the clock edge that follows its acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming token present |
| in_ready | output | 1 | Unit can take a token this cycle |
| in_addr | input | 8 | Target instruction slot |
| in_port | input | 1 | Operand side, 0 left, 1 right |
| in_data | input | 16 | Operand value |
| out_valid | output | 1 | Result token present |
| out_ready | input | 1 | Consumer takes the result token |
| out_addr | output | 8 | Destination slot of the result token |
| out_port | output | 1 | Destination operand side |
| out_data | output | 16 | Result value |
| prog_we | input | 1 | Program memory write strobe |
| prog_addr | input | 8 | Program memory write slot |
| prog_word | input | 25 | Instruction word to write |

## Verification
Every opcode is swept with boundary pairs (all-ones against one, equal zeros, 0x8000 against 0x7FFF) and with computed pairs. Half of the pairs arrive left first and half right first, so a swap of the operand sides shows up through subtraction and comparison. Single-operand tokens on the right port separate arity taken from the instruction from arity taken from the token. A two-destination instruction, run once with the consumer ready and once stalled, separates correct fan-out order and timing from lost or early tokens. Tokens for another slot interleaved with a parked operand, re-use of a slot after firing, and a slot with no destinations that is later reprogrammed show whether the presence flags are set and cleared correctly.

// File: rtl/ttm_pkg.sv
package ttm_pkg;
  // ALU operation codes (R5)
  typedef enum logic [3:0] {
    OP_PASS = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_MUL  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_GT   = 4'd7,
    OP_NEG  = 4'd8
  } ttm_op_e;

  localparam int OP_W    = 4;
  localparam int N_DEST  = 2;
endpackage

// File: rtl/ttm_alu.sv
module ttm_alu
  import ttm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic [DATA_W-1:0] res
);
  logic [2*DATA_W-1:0] prod;

  assign prod = lhs * rhs;

  // R5: operation table
  always_comb begin
    case (op)
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;
      OP_MUL:  res = prod[DATA_W-1:0];
      OP_AND:  res = lhs & rhs;
      OP_OR:   res = lhs | rhs;
      OP_XOR:  res = lhs ^ rhs;
      OP_GT:   res = {{(DATA_W-1){1'b0}}, (lhs > rhs)};
      OP_NEG:  res = '0 - lhs;
      default: res = lhs;
    endcase
  end
endmodule

// File: rtl/ttm_prog_mem.sv
module ttm_prog_mem #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 25,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  // R6: program load port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read, issued when a token is taken
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ttm_match_store.sv
module ttm_match_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  // lookup, registered
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_present,
  output logic              rd_port,
  output logic [DATA_W-1:0] rd_data,
  // update
  input  logic              park_en,
  input  logic              fire_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_port,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DEPTH-1:0]  pres_q;
  logic [DATA_W-1:0] val_mem  [DEPTH];
  logic              port_mem [DEPTH];

  // R1/R3/R4: presence flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q <= '0;
    end else if (park_en) begin
      pres_q[wr_addr] <= 1'b1;
    end else if (fire_en) begin
      pres_q[wr_addr] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (park_en) begin
      val_mem[wr_addr]  <= wr_data;
      port_mem[wr_addr] <= wr_port;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_present <= 1'b0;
    end else if (rd_en) begin
      rd_present <= pres_q[rd_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data <= val_mem[rd_addr];
      rd_port <= port_mem[rd_addr];
    end
  end

  // A slot is parked only while empty
  assert_park_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    park_en |-> !pres_q[wr_addr]);

  // A slot fires as dyadic only while holding an operand
  assert_fire_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_en |-> pres_q[wr_addr]);

  assert_one_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(park_en && fire_en));
endmodule

// File: rtl/ttm_emit.sv
module ttm_emit #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int NDEST  = 2,
  localparam int SW = (NDEST > 1) ? $clog2(NDEST) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [DATA_W-1:0]            value,
  input  logic [NDEST-1:0]             dst_v,
  input  logic [NDEST-1:0][ADDR_W-1:0] dst_addr,
  input  logic [NDEST-1:0]             dst_port,
  output logic                         busy,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [ADDR_W-1:0]            out_addr,
  output logic                         out_port,
  output logic [DATA_W-1:0]            out_data
);
  logic [NDEST-1:0]             pend_q;
  logic [DATA_W-1:0]            val_q;
  logic [NDEST-1:0][ADDR_W-1:0] addr_q;
  logic [NDEST-1:0]             port_q;
  logic [SW-1:0]                sel;
  logic                         found;

  // R7: lowest pending destination goes first
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NDEST; i++) begin
      if (pend_q[i] && !found) begin
        sel   = SW'(i);
        found = 1'b1;
      end
    end
  end

  assign out_valid = |pend_q;
  assign busy      = out_valid;
  assign out_addr  = addr_q[sel];
  assign out_port  = port_q[sel];
  assign out_data  = val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (load) begin
      pend_q <= dst_v;
    end else if (out_valid && out_ready) begin
      pend_q[sel] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      val_q  <= value;
      addr_q <= dst_addr;
      port_q <= dst_port;
    end
  end

  // R8: a stalled token holds steady
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_addr) && $stable(out_port)));

  // R8: no result is overwritten
  assert_load_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

  // R7: the second destination follows at once
  assert_fanout_back2back_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pend_q) > 1 && out_ready) |=> out_valid);
endmodule

// File: rtl/ttm_fire_core.sv
module ttm_fire_core
  import ttm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int DEST_W = ADDR_W + 2,
  localparam int IW     = OP_W + 1 + N_DEST * DEST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_port,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_port,
  output logic [DATA_W-1:0] out_data,
  input  logic              prog_we,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [IW-1:0]     prog_word
);
  // intake stage
  logic              accept;
  logic              sa_valid;
  logic [ADDR_W-1:0] sa_addr;
  logic              sa_port;
  logic [DATA_W-1:0] sa_data;

  // fetched instruction and match lookup
  logic [IW-1:0]     word;
  logic              st_present;
  logic              st_port;
  logic [DATA_W-1:0] st_data;

  // decoded fields (R6)
  logic [OP_W-1:0]                op;
  logic                           dyadic;
  logic [N_DEST-1:0]              d_v;
  logic [N_DEST-1:0][ADDR_W-1:0]  d_addr;
  logic [N_DEST-1:0]              d_port;

  logic              park, fire, fire_dy;
  logic [DATA_W-1:0] lhs, rhs, result;
  logic              emit_busy;

  // R1/R8: one token in flight, none while results are pending
  assign in_ready = !sa_valid && !emit_busy;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_valid <= 1'b0;
    end else begin
      sa_valid <= accept;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      sa_addr <= in_addr;
      sa_port <= in_port;
      sa_data <= in_data;
    end
  end

  ttm_prog_mem #(.ADDR_W(ADDR_W), .WORD_W(IW)) u_prog (
    .clk   (clk),
    .we    (prog_we),
    .waddr (prog_addr),
    .wdata (prog_word),
    .re    (accept),
    .raddr (in_addr),
    .rdata (word)
  );

  ttm_match_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (accept),
    .rd_addr    (in_addr),
    .rd_present (st_present),
    .rd_port    (st_port),
    .rd_data    (st_data),
    .park_en    (park),
    .fire_en    (fire_dy),
    .wr_addr    (sa_addr),
    .wr_port    (sa_port),
    .wr_data    (sa_data)
  );

  // R6: field decode
  assign op     = word[IW-1 -: OP_W];
  assign dyadic = word[IW-1-OP_W];

  for (genvar k = 0; k < N_DEST; k++) begin : g_dest
    localparam int LSB = (N_DEST - 1 - k) * DEST_W;
    assign d_v[k]    = word[LSB + DEST_W - 1];
    assign d_addr[k] = word[LSB + 1 +: ADDR_W];
    assign d_port[k] = word[LSB];
  end

  // R2/R3/R4: match decision
  assign park    = sa_valid && dyadic && !st_present;
  assign fire_dy = sa_valid && dyadic && st_present;
  assign fire    = sa_valid && (!dyadic || st_present);

  // R4: operands ordered by the parked operand's side
  always_comb begin
    if (!dyadic) begin
      lhs = sa_data;
      rhs = '0;
    end else if (st_port) begin
      lhs = sa_data;
      rhs = st_data;
    end else begin
      lhs = st_data;
      rhs = sa_data;
    end
  end

  ttm_alu #(.DATA_W(DATA_W)) u_alu (
    .op  (op),
    .lhs (lhs),
    .rhs (rhs),
    .res (result)
  );

  ttm_emit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NDEST(N_DEST)) u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire),
    .value     (result),
    .dst_v     (d_v),
    .dst_addr  (d_addr),
    .dst_port  (d_port),
    .busy      (emit_busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_port  (out_port),
    .out_data  (out_data)
  );

  // R8: intake closed while a result waits
  assert_intake_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R3: a parked operand emits nothing
  assert_park_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    park |=> !out_valid);

  // R10: a fired instruction with a destination shows up one edge later
  assert_fire_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (|d_v)) |=> out_valid);
endmodule

// File: tb/sim_ttm_fire_core.sv
module sim_ttm_fire_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_addr = '0;
  logic        in_port = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_addr;
  logic        out_port;
  logic [15:0] out_data;
  logic        prog_we = 1'b0;
  logic [7:0]  prog_addr = '0;
  logic [24:0] prog_word = '0;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int acc_cyc = 0;
  int stall_viol = 0;

  int          cap_n = 0;
  logic [7:0]  cap_addr [1024];
  logic        cap_port [1024];
  logic [15:0] cap_data [1024];
  int          cap_cyc  [1024];

  always #10 clk = ~clk;

  ttm_fire_core u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_port(in_port), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_port(out_port), .out_data(out_data),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_word(prog_word)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && in_ready) stall_viol++;
      if (out_valid && out_ready && cap_n < 1024) begin
        cap_addr[cap_n] = out_addr;
        cap_port[cap_n] = out_port;
        cap_data[cap_n] = out_data;
        cap_cyc[cap_n]  = cyc;
        cap_n++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input int op, input logic [15:0] l, input logic [15:0] r);
    logic [31:0] p;
    p = l * r;
    case (op)
      1: return l + r;
      2: return l - r;
      3: return p[15:0];
      4: return l & r;
      5: return l | r;
      6: return l ^ r;
      7: return (l > r) ? 16'd1 : 16'd0;
      8: return 16'd0 - l;
      default: return l;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic prog(input logic [7:0] a, input logic [3:0] op, input logic dy,
                      input logic v0, input logic [7:0] a0, input logic p0,
                      input logic v1, input logic [7:0] a1, input logic p1);
    prog_we   = 1'b1;
    prog_addr = a;
    prog_word = {op, dy, v0, a0, p0, v1, a1, p1};
    tick(1);
    prog_we   = 1'b0;
  endtask

  task automatic send(input logic [7:0] a, input logic p, input logic [15:0] d);
    in_valid = 1'b1;
    in_addr  = a;
    in_port  = p;
    in_data  = d;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    #1;
    acc_cyc  = cyc;
    in_valid = 1'b0;
  endtask

  task automatic wait_caps(input int target);
    for (int i = 0; i < 100; i++) begin
      if (cap_n >= target) break;
      tick(1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int base;
    logic [15:0] l, r;
    tick(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_ready after reset", in_ready, 1);
    chk("R1 out_valid after reset", out_valid, 0);
    tick(1);
    out_ready = 1'b1;

    // R5/R4/R6: opcode sweep, both arrival orders
    for (int op = 0; op < 16; op++) begin
      prog(8'(op), 4'(op), 1'b1, 1'b1, 8'(8'h80 | op), op[0], 1'b0, 8'h00, 1'b0);
      for (int p = 0; p < 6; p++) begin
        case (p)
          0: begin l = 16'hFFFF; r = 16'h0001; end
          1: begin l = 16'h0001; r = 16'hFFFF; end
          2: begin l = 16'h0000; r = 16'h0000; end
          3: begin l = 16'h8000; r = 16'h7FFF; end
          default: begin l = 16'(p * 12345 + op * 77); r = 16'(p * 999 + op * 3); end
        endcase
        base = cap_n;
        if (p[0]) begin
          send(8'(op), 1'b1, r);
          send(8'(op), 1'b0, l);
        end else begin
          send(8'(op), 1'b0, l);
          send(8'(op), 1'b1, r);
        end
        wait_caps(base + 1);
        tick(2);
        chk("R5 result", {16'h0, cap_data[base]}, {16'h0, model(op, l, r)});
        chk("R4 one token per pair", cap_n, base + 1);
        chk("R7 dest address", cap_addr[base], 8'(8'h80 | op));
        if (p == 0) chk("R7 dest port", cap_port[base], op[0]);
      end
    end

    // R3: first arrival parks silently; R9 other slot runs meanwhile
    prog(8'h20, 4'd1, 1'b1, 1'b1, 8'h40, 1'b0, 1'b0, 8'h00, 1'b0);
    prog(8'h21, 4'd2, 1'b1, 1'b1, 8'h41, 1'b1, 1'b0, 8'h00, 1'b0);
    base = cap_n;
    send(8'h20, 1'b0, 16'd5);
    tick(6);
    chk("R3 no output on first arrival", cap_n, base);
    chk("R3 intake open while parked", in_ready, 1);
    send(8'h21, 1'b0, 16'd100);
    send(8'h21, 1'b1, 16'd30);
    wait_caps(base + 1);
    tick(2);
    chk("R9 other slot result", cap_data[base], 16'd70);
    chk("R9 other slot address", cap_addr[base], 8'h41);
    send(8'h20, 1'b1, 16'd7);
    wait_caps(base + 2);
    tick(2);
    chk("R9 parked operand kept", cap_data[base + 1], 16'd12);
    chk("R4 partner result address", cap_addr[base + 1], 8'h40);
    // R4: slot re-arms after firing
    send(8'h20, 1'b1, 16'd1);
    tick(3);
    chk("R4 re-armed slot parks", cap_n, base + 2);
    send(8'h20, 1'b0, 16'd2);
    wait_caps(base + 3);
    tick(2);
    chk("R4 second wave result", cap_data[base + 2], 16'd3);

    // R2/R10: monadic on right port
    prog(8'h30, 4'd8, 1'b0, 1'b1, 8'h50, 1'b1, 1'b0, 8'h00, 1'b0);
    base = cap_n;
    send(8'h30, 1'b1, 16'd5);
    wait_caps(base + 1);
    tick(2);
    chk("R2 monadic negate", cap_data[base], 16'hFFFB);
    chk("R2 monadic port", cap_port[base], 1);
    chk("R10 latency", cap_cyc[base], acc_cyc + 1);

    // R7: two destinations, consumer ready
    prog(8'h31, 4'd0, 1'b0, 1'b1, 8'h60, 1'b0, 1'b1, 8'h61, 1'b1);
    base = cap_n;
    send(8'h31, 1'b0, 16'h1234);
    wait_caps(base + 2);
    tick(2);
    chk("R7 first dest address", cap_addr[base], 8'h60);
    chk("R7 first dest port", cap_port[base], 0);
    chk("R7 second dest address", cap_addr[base + 1], 8'h61);
    chk("R7 second dest port", cap_port[base + 1], 1);
    chk("R7 second dest data", cap_data[base + 1], 16'h1234);
    chk("R7 consecutive cycles", cap_cyc[base + 1], cap_cyc[base] + 1);

    // R8: consumer stalled
    out_ready = 1'b0;
    base = cap_n;
    send(8'h31, 1'b1, 16'h0BEE);
    tick(6);
    @(negedge clk);
    chk("R8 nothing taken while stalled", cap_n, base);
    chk("R8 out_valid held", out_valid, 1);
    chk("R8 address held", out_addr, 8'h60);
    chk("R8 data held", out_data, 16'h0BEE);
    chk("R8 intake closed", in_ready, 0);
    tick(1);
    out_ready = 1'b1;
    wait_caps(base + 2);
    tick(2);
    chk("R8 both tokens after release", cap_n, base + 2);
    chk("R8 order after release", cap_addr[base + 1], 8'h61);

    // R7: no destinations, then reprogram to prove the flag cleared
    prog(8'h32, 4'd6, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
    base = cap_n;
    send(8'h32, 1'b0, 16'h00F0);
    send(8'h32, 1'b1, 16'h0F00);
    tick(6);
    chk("R7 no-dest emits nothing", cap_n, base);
    prog(8'h32, 4'd6, 1'b1, 1'b1, 8'h70, 1'b0, 1'b0, 8'h00, 1'b0);
    send(8'h32, 1'b0, 16'h0003);
    tick(3);
    chk("R6 reprogrammed slot parks", cap_n, base);
    send(8'h32, 1'b1, 16'h0005);
    wait_caps(base + 1);
    tick(2);
    chk("R6 reprogrammed result", cap_data[base], 16'h0006);

    chk("R8 no intake while output pending", stall_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule